// File: doc/BRIEF.md
# Frame and Line Valid Timing Generator

This block produces the frame-valid and line-valid strobes for a raster readout, together with the current row and column counts and a flag that marks border pixels. Software-facing configuration arrives on plain input pins: active width and height, horizontal and vertical blanking lengths, two border control bits and two line-valid mode bits. Downstream logic uses the strobes to frame pixel data and the border flag to put border data in place of array data.

An optional four-pixel border can surround the active array. When the border is shown, each line and the frame both grow by eight. When it is enabled but hidden, the same eight pixels and eight rows are added to the blanking intervals instead, so the total frame period does not change between the two. Line-valid has three forms: gated by frame-valid (normal), running at the row rate through vertical blanking (continuous), or the continuous waveform XORed with frame-valid. All configuration is captured once per frame, at the first pixel of the frame, so a frame never mixes two settings.

Top module: `vtg_frame_timer`

## Requirements
- R1: While rst_n is low, frame_valid, line_valid and border_px are 0, and row_idx and col_idx are 0.
- R2: Each row lasts L+HB clock cycles, where L is the line length and HB the effective horizontal blanking; with no border L equals cfg_width and HB equals cfg_hblank. In normal mode line_valid is high exactly for columns 0 to L-1 of rows where frame_valid is high.
- R3: Each frame lasts A+VB rows, where A is the active row count and VB the effective vertical blanking; with no border A equals cfg_height and VB equals cfg_vblank. frame_valid is high exactly for rows 0 to A-1.
- R4: With the border code {cfg_brd_show, cfg_brd_en} = 11, L = cfg_width+8 and A = cfg_height+8; border_px is high for an active pixel inside the frame whose column is below 4 or at least L-4, or whose row is below 4 or at least A-4, and low elsewhere.
- R5: With the border code 01 (enabled, hidden), L and A are as with no border, HB = cfg_hblank+8, VB = cfg_vblank+8, and border_px stays 0.
- R6: With cfg_brd_en = 0, cfg_brd_show has no effect: the code 10 behaves exactly as 00.
- R7: With cfg_lv_cont = 1, line_valid is high for columns 0 to L-1 of every row of the frame, including vertical blanking rows.
- R8: With cfg_lv_cont = 0 and cfg_lv_xor = 1, line_valid equals the continuous waveform of R7 XORed with frame_valid: low over the active span and high over horizontal blanking in active rows, high over columns 0 to L-1 in blanking rows.
- R9: cfg_lv_xor has no effect while cfg_lv_cont is 1.
- R10: Configuration inputs are captured only at the first pixel of a frame (row 0, column 0); changes made during a frame affect only the next frame.
- R11: col_idx counts 0 to L+HB-1 within each row and row_idx counts 0 to A+VB-1 within each frame, both restarting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | CW | Active pixels per line |
| cfg_height | input | RW | Active rows per frame |
| cfg_hblank | input | CW | Horizontal blanking in pixels |
| cfg_vblank | input | RW | Vertical blanking in rows |
| cfg_brd_en | input | 1 | Border enable |
| cfg_brd_show | input | 1 | Show the border when enabled |
| cfg_lv_cont | input | 1 | Continuous line-valid mode |
| cfg_lv_xor | input | 1 | XOR line-valid mode |
| frame_valid | output | 1 | Frame valid strobe |
| line_valid | output | 1 | Line valid strobe |
| row_idx | output | RW+2 | Row count within the frame |
| col_idx | output | CW+2 | Column count within the row |
| border_px | output | 1 | Current pixel belongs to the shown border |

## Verification
The case that matters most is the last pixel of a frame. In that cycle the column counter wraps, the row counter wraps and the configuration is captured, all on one clock edge. The bench changes the configuration inputs in the middle of every frame, always to a different mode or geometry. A scoreboard then checks every cycle of the following frame against a model built from the new settings only. A capture taken one cycle early or late, or a wrap computed from the wrong frame's lengths, shows up as a misplaced strobe or a wrong index at the first pixels of the new frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Per-frame mode flags held in the shadow register
  typedef struct packed {
    logic show;   // border visible in the active area
    logic cont;   // line-valid runs through vertical blanking
    logic xr;     // line-valid XORed with frame-valid
  } vtg_mode_t;

  localparam int unsigned BORDER_W   = 4;
  localparam int unsigned BORDER_ADD = 2 * BORDER_W;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
#(
  parameter int unsigned CW = 10,
  parameter int unsigned RW = 10,
  localparam int unsigned HW = CW + 2,
  localparam int unsigned VW = RW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] width_i,
  input  logic [RW-1:0] height_i,
  input  logic [CW-1:0] hblank_i,
  input  logic [RW-1:0] vblank_i,
  input  logic          brd_en_i,
  input  logic          brd_show_i,
  input  logic          lv_cont_i,
  input  logic          lv_xor_i,
  output vtg_mode_t     mode_o,
  output logic [HW-1:0] line_len_o,
  output logic [HW-1:0] row_last_o,
  output logic [VW-1:0] rows_act_o,
  output logic [VW-1:0] frame_last_o,
  output logic          pend_o
);
  logic          show_n, hide_n, ld;
  logic [HW-1:0] line_n, hbe_n, row_last_n;
  logic [VW-1:0] rows_n, vbe_n, frame_last_n;
  vtg_mode_t     mode_n;

  logic          pend_q;
  vtg_mode_t     mode_q;
  logic [HW-1:0] line_q, row_last_q;
  logic [VW-1:0] rows_q, frame_last_q;

  always_comb begin
    show_n       = brd_en_i & brd_show_i;
    hide_n       = brd_en_i & ~brd_show_i;
    line_n       = HW'(width_i)  + (show_n ? HW'(BORDER_ADD) : HW'(0));
    hbe_n        = HW'(hblank_i) + (hide_n ? HW'(BORDER_ADD) : HW'(0));
    row_last_n   = line_n + hbe_n - HW'(1);
    rows_n       = VW'(height_i) + (show_n ? VW'(BORDER_ADD) : VW'(0));
    vbe_n        = VW'(vblank_i) + (hide_n ? VW'(BORDER_ADD) : VW'(0));
    frame_last_n = rows_n + vbe_n - VW'(1);
    mode_n.show  = show_n;
    mode_n.cont  = lv_cont_i;
    mode_n.xr    = lv_xor_i & ~lv_cont_i;
    ld           = pend_q | load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b1;
      mode_q       <= '0;
      line_q       <= '0;
      row_last_q   <= '0;
      rows_q       <= '0;
      frame_last_q <= '0;
    end else begin
      pend_q <= 1'b0;
      if (ld) begin
        mode_q       <= mode_n;
        line_q       <= line_n;
        row_last_q   <= row_last_n;
        rows_q       <= rows_n;
        frame_last_q <= frame_last_n;
      end
    end
  end

  assign mode_o       = mode_q;
  assign line_len_o   = line_q;
  assign row_last_o   = row_last_q;
  assign rows_act_o   = rows_q;
  assign frame_last_o = frame_last_q;
  assign pend_o       = pend_q;
endmodule

// File: rtl/vtg_wrap_cnt.sv
module vtg_wrap_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         at_last_o
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    at_last_o = (cnt_q == last_i);
    cnt_n     = cnt_q;
    if (en_i) cnt_n = at_last_o ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  // R11: a running counter never passes its wrap point
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q <= last_i);
  // R11: after the wrap point the count restarts at zero
  p_cnt_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && at_last_o) |=> cnt_q == '0);
endmodule

// File: rtl/vtg_out.sv
module vtg_out
  import vtg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vtg_mode_t     mode_i,
  input  logic [HW-1:0] line_len_i,
  input  logic [VW-1:0] rows_act_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  output logic          fv_o,
  output logic          lv_o,
  output logic          bp_o
);
  logic h_act, edge_c, edge_r;

  always_comb begin
    h_act  = hcnt_i < line_len_i;
    fv_o   = vcnt_i < rows_act_i;
    if (mode_i.cont)    lv_o = h_act;
    else if (mode_i.xr) lv_o = h_act ^ fv_o;
    else                lv_o = h_act & fv_o;
    edge_c = (hcnt_i < HW'(BORDER_W)) || (hcnt_i >= line_len_i - HW'(BORDER_W));
    edge_r = (vcnt_i < VW'(BORDER_W)) || (vcnt_i >= rows_act_i - VW'(BORDER_W));
    bp_o   = mode_i.show & fv_o & h_act & (edge_c | edge_r);
  end

  // R2: in gated mode a line strobe only appears inside the frame
  p_lv_in_fv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.cont && !mode_i.xr && lv_o) |-> fv_o);
  // R4: border pixels lie inside the frame
  p_border_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bp_o |-> fv_o);
  // R8: in XOR mode no line strobe overlaps a shown border pixel
  p_xor_no_border_lv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.xr && bp_o) |-> !lv_o);
endmodule

// File: rtl/vtg_frame_timer.sv
module vtg_frame_timer
  import vtg_pkg::*;
#(
  parameter int unsigned CW = 10,
  parameter int unsigned RW = 10,
  localparam int unsigned HW = CW + 2,
  localparam int unsigned VW = RW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic [CW-1:0] cfg_hblank,
  input  logic [RW-1:0] cfg_vblank,
  input  logic          cfg_brd_en,
  input  logic          cfg_brd_show,
  input  logic          cfg_lv_cont,
  input  logic          cfg_lv_xor,
  output logic          frame_valid,
  output logic          line_valid,
  output logic [VW-1:0] row_idx,
  output logic [CW+1:0] col_idx,
  output logic          border_px
);
  vtg_mode_t     mode;
  logic [HW-1:0] line_len, row_last, hcnt;
  logic [VW-1:0] rows_act, frame_last, vcnt;
  logic          pend, run, h_last, v_last, v_en, frame_end;

  always_comb begin
    run       = ~pend;
    v_en      = run & h_last;
    frame_end = v_en & v_last;
  end

  vtg_shadow #(.CW(CW), .RW(RW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load_i(frame_end),
    .width_i(cfg_width), .height_i(cfg_height),
    .hblank_i(cfg_hblank), .vblank_i(cfg_vblank),
    .brd_en_i(cfg_brd_en), .brd_show_i(cfg_brd_show),
    .lv_cont_i(cfg_lv_cont), .lv_xor_i(cfg_lv_xor),
    .mode_o(mode), .line_len_o(line_len), .row_last_o(row_last),
    .rows_act_o(rows_act), .frame_last_o(frame_last), .pend_o(pend)
  );

  vtg_wrap_cnt #(.W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .en_i(run), .last_i(row_last),
    .cnt_o(hcnt), .at_last_o(h_last)
  );

  vtg_wrap_cnt #(.W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .en_i(v_en), .last_i(frame_last),
    .cnt_o(vcnt), .at_last_o(v_last)
  );

  vtg_out #(.HW(HW), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .line_len_i(line_len), .rows_act_i(rows_act),
    .hcnt_i(hcnt), .vcnt_i(vcnt),
    .fv_o(frame_valid), .lv_o(line_valid), .bp_o(border_px)
  );

  assign row_idx = vcnt;
  assign col_idx = hcnt;

  // R10: the captured settings change only on the first pixel of a frame
  p_cfg_frame_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_len) || !$stable(rows_act) || !$stable(mode))
      |-> (hcnt == '0 && vcnt == '0));
  // R3: frame-valid rises only at row 0, column 0
  p_fv_rise_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> (vcnt == '0 && hcnt == '0));
endmodule

// File: tb/vtg_frame_timer_tb_top.sv
module vtg_frame_timer_tb_top;
  localparam int CW = 10;
  localparam int RW = 10;
  localparam int HW = CW + 2;
  localparam int VW = RW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_width, cfg_hblank;
  logic [RW-1:0] cfg_height, cfg_vblank;
  logic          cfg_brd_en, cfg_brd_show, cfg_lv_cont, cfg_lv_xor;
  logic          frame_valid, line_valid, border_px;
  logic [VW-1:0] row_idx;
  logic [HW-1:0] col_idx;

  typedef struct packed {
    logic [3:0]    fid;
    logic          fv;
    logic          lv;
    logic          bp;
    logic [VW-1:0] row;
    logic [HW-1:0] col;
  } exp_t;

  exp_t  q[$];
  string ftag[16];
  int    total = 0;
  int    bad   = 0;
  bit    mon_on = 1'b0;
  bit    done   = 1'b0;

  always #5 clk = ~clk;

  vtg_frame_timer #(.CW(CW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank),
    .cfg_brd_en(cfg_brd_en), .cfg_brd_show(cfg_brd_show),
    .cfg_lv_cont(cfg_lv_cont), .cfg_lv_xor(cfg_lv_xor),
    .frame_valid(frame_valid), .line_valid(line_valid),
    .row_idx(row_idx), .col_idx(col_idx), .border_px(border_px)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Driver: apply one frame's settings and push its expected cycles
  task automatic push_frame(input int fid, input string tag,
                            input int w, input int h, input int hb, input int vb,
                            input bit en, input bit sh, input bit ct, input bit xr,
                            output int n);
    int l, hbe, a, vbe;
    cfg_width = CW'(w); cfg_height = RW'(h);
    cfg_hblank = CW'(hb); cfg_vblank = RW'(vb);
    cfg_brd_en = en; cfg_brd_show = sh; cfg_lv_cont = ct; cfg_lv_xor = xr;
    ftag[fid] = tag;
    l   = w  + ((en && sh)  ? 8 : 0);
    hbe = hb + ((en && !sh) ? 8 : 0);
    a   = h  + ((en && sh)  ? 8 : 0);
    vbe = vb + ((en && !sh) ? 8 : 0);
    n = 0;
    for (int r = 0; r < a + vbe; r++) begin
      for (int c = 0; c < l + hbe; c++) begin
        exp_t e;
        bit fv, ha;
        fv = (r < a);
        ha = (c < l);
        e.fid = 4'(fid);
        e.fv  = fv;
        if (ct)      e.lv = ha;
        else if (xr) e.lv = ha ^ fv;
        else         e.lv = ha & fv;
        e.bp  = en && sh && fv && ha &&
                (c < 4 || c >= l - 4 || r < 4 || r >= a - 4);
        e.row = VW'(r);
        e.col = HW'(c);
        q.push_back(e);
        n++;
      end
    end
  endtask

  // Wait until the frame whose length is n has begun (its settings captured)
  task automatic wait_started(input int n);
    while (q.size() >= n) @(posedge clk);
    #1;
  endtask

  // Monitor: compare one expected cycle per clock, away from the edge
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({"R3 ", ftag[e.fid]}, int'(frame_valid), int'(e.fv));
      check(ftag[e.fid], int'(line_valid), int'(e.lv));
      check({"R4 ", ftag[e.fid]}, int'(border_px), int'(e.bp));
      check("R11 row", int'(row_idx), int'(e.row));
      check("R11 col", int'(col_idx), int'(e.col));
    end
  end

  initial begin : main
    int n;
    rst_n = 1'b0;
    push_frame(0, "R2", 12, 6, 4, 2, 1'b0, 1'b0, 1'b0, 1'b0, n);
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    check("R1 fv", int'(frame_valid), 0);
    check("R1 lv", int'(line_valid), 0);
    check("R1 bp", int'(border_px), 0);
    check("R1 row", int'(row_idx), 0);
    check("R1 col", int'(col_idx), 0);
    rst_n = 1'b1;
    @(posedge clk);
    mon_on = 1'b1;
    // Each new setting is applied mid-frame; R10 says it waits for the next frame
    wait_started(n);
    push_frame(1, "R4 R10", 12, 6, 4, 3, 1'b1, 1'b1, 1'b0, 1'b0, n);
    wait_started(n);
    push_frame(2, "R5 R10", 12, 6, 4, 2, 1'b1, 1'b0, 1'b0, 1'b0, n);
    wait_started(n);
    push_frame(3, "R6 R10", 10, 5, 3, 2, 1'b0, 1'b1, 1'b0, 1'b0, n);
    wait_started(n);
    push_frame(4, "R7 R10", 12, 6, 3, 3, 1'b0, 1'b0, 1'b1, 1'b0, n);
    wait_started(n);
    push_frame(5, "R8 R10", 12, 6, 3, 3, 1'b0, 1'b0, 1'b0, 1'b1, n);
    wait_started(n);
    push_frame(6, "R9 R10", 12, 6, 3, 3, 1'b0, 1'b0, 1'b1, 1'b1, n);
    wait_started(n);
    push_frame(7, "R4 R8", 9, 4, 0, 0, 1'b1, 1'b1, 1'b0, 1'b1, n);
    wait_started(n);
    push_frame(8, "R2 R10", 5, 3, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0, n);
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule